// File: doc/BRIEF.md
# SPI Register Bank Slave

This block is a serial-peripheral-bus slave that fronts a bank of 64 storage registers, each 24 bits wide. The host exchanges fixed 32-bit full-duplex words with it. Every word opens with a direction flag and a 6-bit register index, and closes with a 24-bit payload. A write word deposits its payload into the indexed register. A read word returns the indexed register on the serial output during the last 24 bit times of the same exchange.

The serial pins are oversampled in the system clock domain. All state changes, including register writes, happen on system clock edges. A write is applied only when the select line falls after exactly 32 clock bits, so an aborted or overlong exchange leaves the bank untouched. Local logic reads any register at any time through a parallel port that is separate from the serial side.

Top module: `spi_regbank_slave`

## Requirements
- R1: After reset, every register reads as zero on the parallel port and the serial output is low.
- R2: A 32-bit word with bit 31 set to 1 stores its bits 23..0 into the register whose index is in bits 30..25. The store takes effect after the select line falls.
- R3: A word with bit 31 at 0 returns the indexed register on the serial output, most significant bit first, in bit times 23..0. Each bit is valid before the serial clock rises (clock idles low, data sampled on the rising edge, select active high).
- R4: The serial output is zero during the first eight bit times (frame bits 31..24) of every exchange.
- R5: Frame bit 24 is reserved. Its value never reaches a register, and it is returned as zero.
- R6: If the select line falls before 32 serial clock bits have been received, no register changes.
- R7: If more than 32 serial clock bits arrive within one select period, no register changes.
- R8: While the select line is low, the serial output is held low.
- R9: A read word never modifies any register, even when its payload field is non-zero.
- R10: The parallel port returns the register at rd_addr on rd_data one system clock after the address is presented.
- R11: Serial clock edges while the select line is low have no effect on registers or on the next exchange.
- R12: A write word returns the value its target register held before that word on the serial output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host, idles low |
| spi_cs | input | 1 | Slave select, active high |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| rd_addr | input | 6 | Parallel read register index |
| rd_data | output | 24 | Parallel read data |

## Verification
The bound checker enforces on every cycle the properties that depend only on the synchronized select line and the bit counter:
- the output is quiet while deselected and during the header bit times;
- a store fires only on a falling select after exactly 32 bits;
- the counter clears and stays bounded.

The values themselves can only be shown by the bench's exchanges against its model. This covers the returned register contents and their bit order, payload storage at the boundary indices, the old value seen during a write, and the unchanged bank after truncated, overlong, read-with-payload and deselected-clock stimulus.

// File: rtl/rb_pkg.sv
package rb_pkg;
   // Default frame geometry of the serial protocol
   localparam int unsigned RB_FRAME_W = 32;
   localparam int unsigned RB_ADDR_W  = 6;
   localparam int unsigned RB_DATA_W  = 24;

   // Parallel read port variant
   typedef enum logic {
      RB_RD_COMB = 1'b0,
      RB_RD_REG  = 1'b1
   } rb_rd_mode_e;

   // Counter width holding 0 .. frame_w+1 (frame_w+1 marks an overlong frame)
   function automatic int unsigned rb_cnt_w(input int unsigned frame_w);
      return $clog2(frame_w + 2);
   endfunction
endpackage

// File: rtl/rb_sync_edge.sv
module rb_sync_edge #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] q,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rb_sync_edge: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("rb_sync_edge: W must be at least 1");
   end

   logic [W-1:0] stg [STAGES];
   logic [W-1:0] prev;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= stg[STAGES-1];
   end

   assign q    = stg[STAGES-1];
   assign rise = stg[STAGES-1] & ~prev;
   assign fall = ~stg[STAGES-1] & prev;
endmodule

// File: rtl/rb_frame_rx.sv
module rb_frame_rx #(
   parameter int unsigned FRAME_W = 32,
   parameter int unsigned ADDR_W  = 6,
   parameter int unsigned DATA_W  = 24,
   parameter int unsigned CNT_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              cs_fall,
   input  logic              sck_rise,
   input  logic              mosi_s,
   output logic [ADDR_W-1:0] look_addr,
   input  logic [DATA_W-1:0] look_data,
   output logic              miso,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  bit_cnt
);
   localparam int unsigned HDR_W    = FRAME_W - DATA_W;
   localparam int unsigned RSV_W    = HDR_W - 1 - ADDR_W;
   localparam int unsigned ADDR_LSB = DATA_W + RSV_W;
   localparam int unsigned LOOK_AT  = 1 + ADDR_W;
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);
   localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);
   localparam logic [CNT_W-1:0] CNT_LOOK = CNT_W'(LOOK_AT);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

   if (HDR_W < ADDR_W + 1) begin : g_bad_hdr
      $error("rb_frame_rx: header too narrow for flag and address");
   end
   if ((1 << CNT_W) < FRAME_W + 2) begin : g_bad_cnt
      $error("rb_frame_rx: CNT_W too small");
   end

   logic [FRAME_W-1:0] shreg;
   logic [DATA_W-1:0]  tx_word;
   logic [CNT_W-1:0]   cnt;
   logic [CNT_W-1:0]   sel;
   logic [DATA_W-1:0]  tx_shift;
   logic               miso_d;

   // bit counter and receive shifter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         shreg <= '0;
      end else if (!cs_s) begin
         cnt   <= '0;
         shreg <= '0;
      end else if (sck_rise) begin
         if (cnt < CNT_FULL) shreg <= {shreg[FRAME_W-2:0], mosi_s};
         if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
      end
   end

   // address is complete once flag and address bits are in
   assign look_addr = shreg[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       tx_word <= '0;
      else if (cs_s && cnt == CNT_LOOK) tx_word <= look_data;
   end

   // output bit for the current bit time
   assign sel      = CNT_LAST - cnt;
   assign tx_shift = tx_word >> sel;
   assign miso_d   = cs_s && (cnt >= CNT_HDR) && (cnt < CNT_FULL) && tx_shift[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) miso <= 1'b0;
      else        miso <= miso_d;
   end

   // commit only a complete write frame
   assign wr_en   = cs_fall && (cnt == CNT_FULL) && shreg[FRAME_W-1];
   assign wr_addr = shreg[ADDR_LSB +: ADDR_W];
   assign wr_data = shreg[DATA_W-1:0];
   assign bit_cnt = cnt;

   if (RSV_W > 0) begin : g_rsv
      logic rsv_unused;
      assign rsv_unused = ^shreg[DATA_W +: RSV_W];
   end
endmodule

// File: rtl/rb_reg_bank.sv
module rb_reg_bank
   import rb_pkg::*;
#(
   parameter int unsigned ADDR_W  = 6,
   parameter int unsigned DATA_W  = 24,
   parameter rb_rd_mode_e RD_MODE = RB_RD_REG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] look_addr,
   output logic [DATA_W-1:0] look_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   if (DEPTH * DATA_W > 4096) begin : g_bad_size
      $error("rb_reg_bank: bank exceeds flop budget");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign look_data = mem[look_addr];

   if (RD_MODE == RB_RD_REG) begin : g_rd_reg
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= mem[rd_addr];
      end
      assign rd_data = rd_q;
   end else begin : g_rd_comb
      assign rd_data = mem[rd_addr];
   end
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
   import rb_pkg::*;
#(
   parameter int unsigned FRAME_W     = RB_FRAME_W,
   parameter int unsigned ADDR_W      = RB_ADDR_W,
   parameter int unsigned DATA_W      = RB_DATA_W,
   parameter int unsigned SYNC_STAGES = 2,
   parameter rb_rd_mode_e RD_MODE     = RB_RD_REG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs,
   input  logic              spi_mosi,
   output logic              spi_miso,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned CNT_W = rb_cnt_w(FRAME_W);

   if (FRAME_W <= DATA_W + ADDR_W) begin : g_bad_frame
      $error("spi_regbank_slave: FRAME_W too small for address and data");
   end

   logic [2:0]        pin_s, pin_rise, pin_fall;
   logic              cs_s, cs_fall, sck_rise, mosi_s;
   logic [ADDR_W-1:0] look_addr, wr_addr;
   logic [DATA_W-1:0] look_data, wr_data;
   logic              wr_en;
   logic [CNT_W-1:0]  bit_cnt;
   logic              edge_unused;

   // [0] sck, [1] cs, [2] mosi
   rb_sync_edge #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({spi_mosi, spi_cs, spi_sck}),
      .q    (pin_s),
      .rise (pin_rise),
      .fall (pin_fall)
   );

   assign sck_rise    = pin_rise[0];
   assign cs_s        = pin_s[1];
   assign cs_fall     = pin_fall[1];
   assign mosi_s      = pin_s[2];
   assign edge_unused = ^{pin_s[0], pin_rise[2:1], pin_fall[2], pin_fall[0]};

   rb_frame_rx #(
      .FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
   ) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_s     (cs_s),
      .cs_fall  (cs_fall),
      .sck_rise (sck_rise),
      .mosi_s   (mosi_s),
      .look_addr(look_addr),
      .look_data(look_data),
      .miso     (spi_miso),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .bit_cnt  (bit_cnt)
   );

   rb_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_MODE(RD_MODE)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .look_addr(look_addr),
      .look_data(look_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data)
   );
endmodule

// File: rtl/rb_chk.sv
module rb_chk #(
   parameter int unsigned FRAME_W = 32,
   parameter int unsigned DATA_W  = 24,
   parameter int unsigned CNT_W   = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_s,
   input logic             cs_fall,
   input logic [CNT_W-1:0] cnt,
   input logic             miso,
   input logic             wr_en
);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);
   localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(FRAME_W - DATA_W);

   // R8
   miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> !miso);

   // R4
   hdr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_s && cnt < CNT_HDR) |=> !miso);

   // R6
   full_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (cs_fall && cnt == CNT_FULL));

   // R11
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> (cnt == '0));

   // R7
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_OVER);
endmodule

bind spi_regbank_slave rb_chk #(
   .FRAME_W(FRAME_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .cs_s   (cs_s),
   .cs_fall(cs_fall),
   .cnt    (bit_cnt),
   .miso   (spi_miso),
   .wr_en  (wr_en)
);

// File: tb/tb_spi_regbank_slave.sv
module tb_spi_regbank_slave;
   localparam int CLK_PERIOD = 10;
   localparam int HP         = 4;
   localparam int WDOG       = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_sck = 1'b0, spi_cs = 1'b0, spi_mosi = 1'b0;
   logic        spi_miso;
   logic [5:0]  rd_addr = '0;
   logic [23:0] rd_data;

   logic [23:0] ref_bank [64];
   int n_vec = 0, n_bad = 0, low_cnt = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_regbank_slave dut (
      .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs(spi_cs),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // host exchange; checks every returned bit against the model
   task automatic xfer(input logic [31:0] word, input int nbits, input string req);
      logic [31:0] expw;
      expw = {8'h00, ref_bank[word[30:25]]};
      spi_cs = 1'b1;
      wait_clk(HP);
      for (int i = 0; i < nbits; i++) begin
         spi_mosi = (i < 32) ? word[31-i] : 1'b1;
         wait_clk(HP);
         if (i < 32) check(spi_miso == expw[31-i], req, {31'd0, spi_miso}, {31'd0, expw[31-i]});
         spi_sck = 1'b1;
         wait_clk(HP);
         spi_sck = 1'b0;
      end
      wait_clk(HP);
      spi_cs   = 1'b0;
      spi_mosi = 1'b0;
      wait_clk(8);
      if (nbits == 32 && word[31]) ref_bank[word[30:25]] = word[23:0];
   endtask

   task automatic port_chk(input logic [5:0] a, input string req);
      rd_addr = a;
      wait_clk(1);
      check(rd_data == ref_bank[a], req, {8'h0, rd_data}, {8'h0, ref_bank[a]});
   endtask

   function automatic logic [31:0] mk(input bit wr, input logic [5:0] a, input logic [23:0] d);
      return {wr, a, 1'b0, d};
   endfunction

   // R8: every clock, output low once select has been low a few cycles
   always @(negedge clk) begin
      if (rst_n) begin
         if (!spi_cs) low_cnt++;
         else         low_cnt = 0;
         if (low_cnt >= 4) check(spi_miso == 1'b0, "R8 idle low", {31'd0, spi_miso}, 32'd0);
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) ref_bank[i] = '0;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(2);
      // R1 reset state
      check(spi_miso == 1'b0, "R1 miso", {31'd0, spi_miso}, 32'd0);
      for (int i = 0; i < 64; i++) port_chk(6'(i), "R1 reset value");

      // R2 write, R12 old value returned during write
      xfer(mk(1, 6'd5, 24'hABCDEF), 32, "R12 old on write");
      port_chk(6'd5, "R2 write stored");
      // R3, R4 readback
      xfer(mk(0, 6'd5, 24'h000000), 32, "R3/R4 read data");
      // R5 reserved bit set on write
      xfer(mk(1, 6'd63, 24'h123456) | 32'h0100_0000, 32, "R12 old on write");
      port_chk(6'd63, "R5 reserved ignored");
      xfer(mk(0, 6'd63, 24'h0), 32, "R5/R3 read reserved zero");
      // boundary addresses and patterns
      xfer(mk(1, 6'd0, 24'hFFFFFF), 32, "R2 write idx0");
      xfer(mk(1, 6'd62, 24'h800001), 32, "R2 write idx62");
      port_chk(6'd0, "R2 idx0");
      port_chk(6'd62, "R2 idx62");
      xfer(mk(0, 6'd0, 24'h0), 32, "R3 read all ones");
      xfer(mk(0, 6'd62, 24'h0), 32, "R3 read edge bits");
      // R9 read with payload
      xfer(mk(0, 6'd5, 24'h5A5A5A), 32, "R9 read payload");
      port_chk(6'd5, "R9 unchanged");
      // R6 truncated write frames
      xfer(mk(1, 6'd5, 24'h111111), 20, "R6 short frame miso");
      port_chk(6'd5, "R6 short 20");
      xfer(mk(1, 6'd5, 24'h222222), 31, "R6 short frame miso");
      port_chk(6'd5, "R6 short 31");
      // R7 overlong write frame
      xfer(mk(1, 6'd5, 24'h333333), 33, "R7 long frame miso");
      port_chk(6'd5, "R7 long 33");
      // R11 clock activity while deselected
      spi_mosi = 1'b1;
      for (int i = 0; i < 40; i++) begin
         spi_sck = 1'b1; wait_clk(2);
         spi_sck = 1'b0; wait_clk(2);
      end
      spi_mosi = 1'b0;
      wait_clk(4);
      check(spi_miso == 1'b0, "R11 miso quiet", {31'd0, spi_miso}, 32'd0);
      port_chk(6'd5, "R11 bank unchanged");
      xfer(mk(0, 6'd62, 24'h0), 32, "R11 next frame read");
      // R12 overwrite returns previous contents
      xfer(mk(1, 6'd5, 24'h0F0F0F), 32, "R12 old on overwrite");
      xfer(mk(0, 6'd5, 24'h0), 32, "R3 read new value");
      // R10 full scan of the parallel port
      for (int i = 0; i < 64; i++) port_chk(6'(i), "R10 parallel read");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (WDOG) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog all requirements: actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule